// File: doc/BRIEF.md
# Quadrant-Direction Asynchronous FIFO

This block carries data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Words are held in a dual-port register array. The array can be inferred as block RAM: a write port runs on the write clock and a registered read port runs on the read clock. Each side steps its own binary address counter. Each side also publishes a Gray-coded copy of that counter, which crosses into the other clock domain through a two-stage flip-flop chain.

The pointers carry no extra wrap bit. Equal pointers therefore mean either an empty ring or a full one. To tell the two apart, each domain keeps a one-bit lean flag driven by the top two address bits, which split the ring into four quadrants. The flag leans towards full when the writer sits one quadrant behind the reader. It leans towards empty when the reader sits one quadrant behind the writer.

Each side also builds an occupancy estimate from its own pointer and the synchronized pointer of the other side. From this estimate it raises almost-full or almost-empty early, so a producer or consumer can keep a margin before the hard limit.

Top module: `qdir_async_fifo`

## Requirements
- R1: Every accepted word is delivered exactly once and in write order. This holds when the write clock is four times faster than the read clock, and when the ratio is reversed.
- R2: One rst pulse returns the block to an idle state: empty=1, almost_empty=1, full=0, almost_full=0. The pulse must be held for at least two edges of each clock.
- R3: A write attempted while full=1 is dropped. The write pointer does not move, no stored word changes, and the DEPTH words already stored are read back unchanged.
- R4: A read attempted while empty=1 is dropped. rd_data keeps its value, the read pointer does not move, and the next accepted read returns the oldest word written afterwards.
- R5: With no reads, full is 0 after DEPTH-1 writes. full rises on the write-clock edge that takes word DEPTH. Once the pointers have crossed, the read side shows empty=0 and almost_empty=0.
- R6: empty stays 0 while one word remains. empty rises on the read-clock edge that takes the last word.
- R7: almost_full is 1 exactly when the write-side occupancy estimate is at least DEPTH-AF_MARGIN. With the defaults this means 27 words give 0 and 28 words give 1.
- R8: almost_empty is 1 exactly when the read-side occupancy estimate is at most AE_MARGIN. With the defaults this means 5 words give 0 and 4 words give 1.
- R9: The word taken by an accepted read appears on rd_data at the read-clock edge that accepts the read. It is sampled one read-clock cycle after rd_en was raised.
- R10: full and empty stay correct after both pointers have wrapped the ring many times from an arbitrary position. The lean flag holds its value while both pointers sit in the same quadrant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset, sampled synchronously by each clock |
| wclk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry as seen from the write side |
| almost_full | output | 1 | Write-side occupancy at or above DEPTH-AF_MARGIN |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| empty | output | 1 | No stored word as seen from the read side |
| almost_empty | output | 1 | Read-side occupancy at or below AE_MARGIN |

## Verification
Single writes and reads spaced apart pin down the exact edge at which full, empty and the two margin flags change. Attempts made while full or empty then show that a blocked request leaves no trace in the data later read back. Free-running streams with random gaps, first with a fast writer and then with a fast reader, make the synchronized pointers jump several steps at once. These streams show whether the lean flag follows those jumps without confusing a full ring with an empty one. Repeating the fill-and-drain pattern after the streams checks the same boundaries at pointer positions that have wrapped many times.

// File: rtl/qdir_fifo_pkg.sv
`timescale 1ns/1ps
package qdir_fifo_pkg;
  // Which way the ring leans when the two pointers meet.
  typedef enum logic {
    LEAN_EMPTY = 1'b0,
    LEAN_FULL  = 1'b1
  } lean_e;
endpackage

// File: rtl/qdir_mem.sv
`timescale 1ns/1ps
module qdir_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/qdir_ptr_cdc.sv
`timescale 1ns/1ps
module qdir_ptr_cdc #(
  parameter int W = 5
) (
  input  logic         rst,
  input  logic         src_clk,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] src_gray;
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // Registered Gray copy: only one bit changes per step.
  always_ff @(posedge src_clk) begin
    if (rst) src_gray <= '0;
    else     src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  // Gray back to binary: each bit is the XOR of itself and all higher bits.
  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign dst_bin[i] = ^sync_q[W-1:i];
  end
endmodule

// File: rtl/qdir_lean.sv
`timescale 1ns/1ps
module qdir_lean
  import qdir_fifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_bin,
  input  logic [ADDR_W-1:0] rd_bin,
  output lean_e             lean
);
  logic [1:0] wq, rq, wq_next, rq_next;
  logic       to_full, to_empty;

  assign wq       = wr_bin[ADDR_W-1 -: 2];
  assign rq       = rd_bin[ADDR_W-1 -: 2];
  assign wq_next  = wq + 2'd1;
  assign rq_next  = rq + 2'd1;
  assign to_full  = (wq_next == rq);  // writer one quadrant behind reader
  assign to_empty = (rq_next == wq);  // reader one quadrant behind writer

  always_ff @(posedge clk) begin
    if (rst)           lean <= LEAN_EMPTY;
    else if (to_full)  lean <= LEAN_FULL;
    else if (to_empty) lean <= LEAN_EMPTY;
  end

  // R10: with both pointers in one quadrant the flag must not change.
  assert_lean_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (wq == rq) |=> $stable(lean));
endmodule

// File: rtl/qdir_async_fifo.sv
`timescale 1ns/1ps
module qdir_async_fifo
  import qdir_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 32,
  parameter int AF_MARGIN = 4,
  parameter int AE_MARGIN = 4
) (
  input  logic              rst,
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  input  logic              rclk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] AF_LEVEL = CNT_W'(DEPTH - AF_MARGIN);
  localparam logic [CNT_W-1:0] AE_LEVEL = CNT_W'(AE_MARGIN);

  logic [ADDR_W-1:0] w_bin, r_bin;
  logic [ADDR_W-1:0] rs_bin, ws_bin;  // peer pointers after synchronization
  lean_e             w_lean, r_lean;
  logic [ADDR_W-1:0] w_diff, r_diff;
  logic [CNT_W-1:0]  w_cnt, r_cnt;
  logic              wr_ok, rd_ok;

  // ---------------- write domain ----------------
  assign w_diff      = w_bin - rs_bin;
  assign full        = (w_diff == '0) && (w_lean == LEAN_FULL);
  assign w_cnt       = full ? CNT_FULL : {1'b0, w_diff};
  assign almost_full = (w_cnt >= AF_LEVEL);
  assign wr_ok       = wr_en && !full;

  always_ff @(posedge wclk) begin
    if (rst)        w_bin <= '0;
    else if (wr_ok) w_bin <= w_bin + ADDR_W'(1);
  end

  // ---------------- read domain ----------------
  assign r_diff       = ws_bin - r_bin;
  assign empty        = (r_diff == '0) && (r_lean == LEAN_EMPTY);
  assign r_cnt        = ((r_diff == '0) && !empty) ? CNT_FULL : {1'b0, r_diff};
  assign almost_empty = (r_cnt <= AE_LEVEL);
  assign rd_ok        = rd_en && !empty;

  always_ff @(posedge rclk) begin
    if (rst)        r_bin <= '0;
    else if (rd_ok) r_bin <= r_bin + ADDR_W'(1);
  end

  // ---------------- structure ----------------
  qdir_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_ok), .waddr(w_bin), .wdata(wr_data),
    .rclk(rclk), .re(rd_ok), .raddr(r_bin), .rdata(rd_data)
  );

  qdir_ptr_cdc #(.W(ADDR_W)) u_w2r (
    .rst(rst), .src_clk(wclk), .src_bin(w_bin), .dst_clk(rclk), .dst_bin(ws_bin)
  );

  qdir_ptr_cdc #(.W(ADDR_W)) u_r2w (
    .rst(rst), .src_clk(rclk), .src_bin(r_bin), .dst_clk(wclk), .dst_bin(rs_bin)
  );

  qdir_lean #(.ADDR_W(ADDR_W)) u_wlean (
    .clk(wclk), .rst(rst), .wr_bin(w_bin), .rd_bin(rs_bin), .lean(w_lean)
  );

  qdir_lean #(.ADDR_W(ADDR_W)) u_rlean (
    .clk(rclk), .rst(rst), .wr_bin(ws_bin), .rd_bin(r_bin), .lean(r_lean)
  );

  // ---------------- checks ----------------
  assert_no_write_when_full_R3: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && full) |=> $stable(w_bin));

  assert_no_read_when_empty_R4: assert property (@(posedge rclk) disable iff (rst)
    (rd_en && empty) |=> ($stable(r_bin) && $stable(rd_data)));

  assert_reset_idle_R2: assert property (@(posedge rclk) disable iff (rst)
    $past(rst) |-> (empty && almost_empty));

  assert_full_is_almost_R7: assert property (@(posedge wclk) disable iff (rst)
    full |-> almost_full);

  assert_empty_is_almost_R8: assert property (@(posedge rclk) disable iff (rst)
    empty |-> almost_empty);
endmodule

// File: tb/qdir_async_fifo_test.sv
`timescale 1ns/1ps
module qdir_async_fifo_test;
  localparam int DW    = 8;
  localparam int DEPTH = 32;
  localparam int AFM   = 4;
  localparam int AEM   = 4;

  logic          rst = 1'b1;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, almost_full, empty, almost_empty;

  int whalf = 4;   // 125 MHz write clock
  int rhalf = 16;  // read clock four times slower
  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] model_q[$];

  qdir_async_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AF_MARGIN(AFM), .AE_MARGIN(AEM)) uut (
    .rst(rst), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .almost_full(almost_full),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty)
  );

  initial forever #(whalf) wclk = ~wclk;
  initial forever #(rhalf) rclk = ~rclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
  endtask

  task automatic apply_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    @(negedge wclk) rst = 1'b0;
    model_q.delete();
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = d;
    if (!full) model_q.push_back(d);
    @(negedge wclk) wr_en = 1'b0;
  endtask

  // Raise rd_en for one cycle; the word must show one read-clock cycle later (R9).
  task automatic rd_word(input string req);
    bit acc;
    logic [DW-1:0] exp;
    @(negedge rclk);
    rd_en = 1'b1; acc = !empty;
    @(negedge rclk) rd_en = 1'b0;
    if (acc) begin
      if (model_q.size() == 0) chk(1'b0, {req, " R1 spurious read"}, 1, 0);
      else begin
        exp = model_q.pop_front();
        chk(rd_data == exp, {req, " R9 word"}, int'(rd_data), int'(exp));
      end
    end
  endtask

  task automatic t_reset_state();
    chk(empty == 1'b1, "R2 empty", int'(empty), 1);
    chk(almost_empty == 1'b1, "R2 almost_empty", int'(almost_empty), 1);
    chk(full == 1'b0, "R2 full", int'(full), 0);
    chk(almost_full == 1'b0, "R2 almost_full", int'(almost_full), 0);
  endtask

  task automatic t_fill_drain(input string tag);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - AFM - 1) chk(almost_full == 1'b0, {tag, " R7 below margin"}, int'(almost_full), 0);
      wr_word(DW'($urandom));
      if (i == DEPTH - AFM - 1) chk(almost_full == 1'b1, {tag, " R7 at margin"}, int'(almost_full), 1);
      if (i == DEPTH - 2) chk(full == 1'b0, {tag, " R5 one short"}, int'(full), 0);
    end
    chk(full == 1'b1, {tag, " R5 full at DEPTH"}, int'(full), 1);
    settle();
    chk(empty == 1'b0, {tag, " R5 read side not empty"}, int'(empty), 0);
    chk(almost_empty == 1'b0, {tag, " R5 read side not almost_empty"}, int'(almost_empty), 0);
    repeat (3) wr_word(8'hEE);
    chk(full == 1'b1, {tag, " R3 still full"}, int'(full), 1);
    chk(model_q.size() == DEPTH, {tag, " R3 nothing taken"}, model_q.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk(empty == 1'b0, {tag, " R6 one left"}, int'(empty), 0);
      rd_word({tag, " R3 readback"});
    end
    chk(empty == 1'b1, {tag, " R6 empty after last"}, int'(empty), 1);
    settle();
    chk(full == 1'b0 && almost_full == 1'b0, {tag, " R10 write side idle"}, int'({full, almost_full}), 0);
  endtask

  task automatic t_empty_reads();
    logic [DW-1:0] hold;
    settle();
    hold = rd_data;
    repeat (3) @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    chk(rd_data == hold, "R4 rd_data held", int'(rd_data), int'(hold));
    chk(empty == 1'b1, "R4 still empty", int'(empty), 1);
    for (int i = 0; i < AEM + 1; i++) wr_word(DW'(8'h30 + i));
    settle();
    chk(almost_empty == 1'b0, "R8 five words", int'(almost_empty), 0);
    rd_word("R4 first word after blocked reads");
    chk(almost_empty == 1'b1, "R8 four words", int'(almost_empty), 1);
    for (int i = 0; i < AEM; i++) rd_word("R8 drain");
    chk(empty == 1'b1, "R6 drained", int'(empty), 1);
  endtask

  task automatic t_stream(input int n, input string tag);
    fork
      begin : writer
        int sent = 0;
        while (sent < n) begin
          @(negedge wclk);
          if ($urandom % 4 != 0) begin
            wr_en = 1'b1; wr_data = DW'($urandom);
            if (!full) begin model_q.push_back(wr_data); sent++; end
          end else wr_en = 1'b0;
        end
        @(negedge wclk) wr_en = 1'b0;
      end
      begin : reader
        int got = 0;
        bit pend = 1'b0;
        logic [DW-1:0] exp;
        while (got < n) begin
          @(negedge rclk);
          if (pend) begin
            exp = model_q.pop_front();
            chk(rd_data == exp, {tag, " R1 order"}, int'(rd_data), int'(exp));
            got++;
          end
          rd_en = (got < n) && ($urandom % 5 != 0) && !empty;
          pend  = rd_en;
        end
        rd_en = 1'b0;
      end
    join
    settle();
    chk(model_q.size() == 0, {tag, " R1 nothing left over"}, model_q.size(), 0);
    chk(empty == 1'b1, {tag, " R1 empty at end"}, int'(empty), 1);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    apply_reset();
    t_reset_state();
    t_fill_drain("fastwr");
    t_empty_reads();
    t_stream(300, "fastwr");
    t_fill_drain("R10 wrapped fastwr");
    whalf = 16; rhalf = 4;
    apply_reset();
    t_reset_state();
    t_stream(300, "fastrd");
    t_fill_drain("R10 wrapped fastrd");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule